// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is a 32-line general-purpose I/O port controlled through a simple word-wide register bus. Software writes four registers: the output level, the per-line direction, the per-line blink enable and the per-line input polarity. A fifth register, which can only be read, returns the synchronized pin levels after polarity correction. The block drives a pad output value and a pad output enable for every line.

Lines with blinking enabled do not follow their output bit. They follow one square wave that a free-running divider makes, and every blinking line switches at the same moment. The polarity-corrected input vector also leaves the block on its own port, for an interrupt unit that sits outside this block.

The bus is word-addressed. Address bits [1:0] are ignored. A write takes effect at the clock edge on which `wr_en` is high. Read data is combinational from `addr`.

Top module: `gpio_bank`

## Requirements
- R1: At reset every writable register clears to 0. Every line then comes up as an output (`pin_oe` all ones) driving low (`pin_out` all zeros).
- R2: The output-level register sits at offset 0x00 and reads back what was last written. On a line with blinking off, `pin_out` equals this register's bit.
- R3: The direction register sits at offset 0x04 and reads back what was written. A 1 bit makes that line an input, and `pin_oe` for that bit is the inverse of it.
- R4: The output-level register keeps its value while a line is an input. When the line is switched back to output, `pin_out` shows the level that was written earlier.
- R5: The polarity register sits at offset 0x0C and reads back what was written. Offset 0x10 reads the synchronized pin vector XORed bit by bit with it, so a polarity bit of 1 inverts that line.
- R6: A pin change reaches offset 0x10 and `in_view` only after two clock edges. After one edge the old value still shows.
- R7: The blink-enable register sits at offset 0x08 and reads back what was written. A line with its blink bit set drives a shared wave on `pin_out`. The wave is low for the first BLINK_HALF cycles after reset and then toggles every BLINK_HALF cycles.
- R8: Writes to offset 0x10 and to unmapped offsets (0x14, 0x18, 0x1C) change no register. Reads of unmapped offsets return 0.
- R9: `in_view` always equals the value that offset 0x10 reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables, 1 = driving |
| in_view | output | 32 | Polarity-corrected synchronized inputs |

## Verification
The bench goes after the one-edge point of the synchronizer: a design with a single flop would already show the new input there. It also checks the first blink transition against a cycle count kept in the bench, which would expose a divider that is off by one or starts high. Writes to the read-only and unmapped offsets are followed by read-backs of every register, which would expose an address decode that aliases them onto a real register. Switching a line to input, rewriting its level and switching it back would catch a design that clears the output bit when the direction changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned GB_LINES = 32;

    typedef enum logic [2:0] {
        GB_SEL_LEVEL = 3'd0,
        GB_SEL_DIR   = 3'd1,
        GB_SEL_BLINK = 3'd2,
        GB_SEL_POL   = 3'd3,
        GB_SEL_DIN   = 3'd4
    } gb_sel_e;

    typedef struct packed {
        logic [GB_LINES-1:0] level;
        logic [GB_LINES-1:0] dir_in;
        logic [GB_LINES-1:0] blink;
        logic [GB_LINES-1:0] pol;
    } gb_regs_t;

    function automatic logic [2:0] gb_word(input logic [7:0] byte_addr);
        return byte_addr[4:2];
    endfunction

    function automatic logic gb_mapped(input logic [7:0] byte_addr);
        return byte_addr[7:5] == 3'd0 && byte_addr[4:2] <= 3'd4;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [GB_LINES-1:0] din,
    output logic [GB_LINES-1:0] dout
);
    logic [GB_LINES-1:0] meta_q;
    logic [GB_LINES-1:0] stable_q;
    logic [1:0]          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
            seen_q   <= '0;
        end else begin
            meta_q   <= din;
            stable_q <= meta_q;
            if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
        end
    end

    assign dout = stable_q;

    // R6: two edges from pin to synchronized output
    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
    parameter int unsigned HALF = 16
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;

    // R7: phase moves only at the end of a half period
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != LAST) |=> $stable(phase_q));
    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    input  logic [GB_LINES-1:0] din_view,
    output logic [31:0]         rdata,
    output gb_regs_t            regs
);
    localparam int unsigned PAD_W = 8 - ADDR_W;

    logic [7:0] addr8;
    logic [2:0] word;
    logic       mapped;
    gb_regs_t   regs_q;

    assign addr8  = {{PAD_W{1'b0}}, addr};
    assign word   = gb_word(addr8);
    assign mapped = gb_mapped(addr8);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && mapped) begin
            unique case (word)
                GB_SEL_LEVEL: regs_q.level  <= wdata;
                GB_SEL_DIR:   regs_q.dir_in <= wdata;
                GB_SEL_BLINK: regs_q.blink  <= wdata;
                GB_SEL_POL:   regs_q.pol    <= wdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (mapped) begin
            unique case (word)
                GB_SEL_LEVEL: rdata = regs_q.level;
                GB_SEL_DIR:   rdata = regs_q.dir_in;
                GB_SEL_BLINK: rdata = regs_q.blink;
                GB_SEL_POL:   rdata = regs_q.pol;
                GB_SEL_DIN:   rdata = din_view;
                default:      rdata = '0;
            endcase
        end
    end

    assign regs = regs_q;

    // R8: read-only and unmapped writes leave every register alone
    a_r8_ro_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (!mapped || word == GB_SEL_DIN)) |=> $stable(regs_q));
    // R4: output level changes only through its own offset
    a_r4_level_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && mapped && word == GB_SEL_LEVEL) |=> $stable(regs_q.level));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned BLINK_HALF = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic [31:0]       in_view
);
    gb_regs_t            regs;
    logic [GB_LINES-1:0] synced;
    logic [GB_LINES-1:0] corrected;
    logic                phase;

    gpio_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (synced)
    );

    gpio_blink_div #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    assign corrected = synced ^ regs.pol;

    gpio_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .din_view (corrected),
        .rdata    (rdata),
        .regs     (regs)
    );

    for (genvar i = 0; i < GB_LINES; i++) begin : g_line
        assign pin_out[i] = regs.blink[i] ? phase : regs.level[i];
        assign pin_oe[i]  = ~regs.dir_in[i];
    end

    assign in_view = corrected;

    // R1: first cycle after reset shows outputs driving low
    logic was_rst;
    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (was_rst && !rst) begin
            a_r1_reset_pins: assert (pin_oe == '1 && pin_out == '0);
        end
    end

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int unsigned HALF = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [31:0] in_view;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int ncyc   = 0;

    logic [31:0] m_level, m_dir, m_blink, m_pol, m_pin;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    gpio_bank #(.ADDR_W(5), .BLINK_HALF(HALF)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .in_view(in_view)
    );

    function automatic logic exp_phase(int n);
        return ((n / HALF) % 2) != 0;
    endfunction

    function automatic logic [31:0] exp_out(logic [31:0] lv, logic [31:0] bl, int n);
        return (lv & ~bl) | (bl & {32{exp_phase(n)}});
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a[4:2])
            3'd0: m_level = d;
            3'd1: m_dir   = d;
            3'd2: m_blink = d;
            3'd3: m_pol   = d;
            default: ;
        endcase
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_all_regs(string req);
        logic [31:0] v;
        bus_read(5'h00, v); check(req, v, m_level);
        bus_read(5'h04, v); check(req, v, m_dir);
        bus_read(5'h08, v); check(req, v, m_blink);
        bus_read(5'h0C, v); check(req, v, m_pol);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_level = '0; m_dir = '0; m_blink = '0; m_pol = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h1234_5eed));
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
        m_pin = '0;
        do_reset();
        @(negedge clk);

        // R1 reset state
        check("R1 oe", pin_oe, 32'hFFFF_FFFF);
        check("R1 out", pin_out, 32'h0);
        check_all_regs("R1 regs");

        // R2 level write and pin follow
        bus_write(5'h00, 32'hA5A5_0F0F);
        check_all_regs("R2 readback");
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);

        // R3 direction
        bus_write(5'h04, 32'h0000_FFFF);
        check_all_regs("R3 readback");
        check("R3 pin_oe", pin_oe, 32'hFFFF_0000);

        // R4 preset while input, then switch to output
        bus_write(5'h00, 32'h0000_1234);
        check("R4 oe while input", pin_oe, 32'hFFFF_0000);
        bus_write(5'h04, 32'h0);
        check("R4 preset level", pin_out, 32'h0000_1234);
        check("R4 oe restored", pin_oe, 32'hFFFF_FFFF);

        // R5/R6/R9 polarity, latency and export
        bus_write(5'h0C, 32'hFF00_FF00);
        @(negedge clk);
        pin_in = 32'h1357_9BDF;
        @(posedge clk);
        @(negedge clk);
        bus_read(5'h10, v);
        check("R6 one edge old value", v, 32'h0 ^ m_pol);
        @(negedge clk);
        bus_read(5'h10, v);
        check("R5 data-in xor pol", v, 32'h1357_9BDF ^ 32'hFF00_FF00);
        check("R9 in_view", in_view, v);
        m_pin = pin_in;

        // R8 writes to read-only and unmapped offsets
        bus_write(5'h10, 32'hDEAD_BEEF);
        bus_write(5'h14, 32'hDEAD_BEEF);
        bus_write(5'h1C, 32'hCAFE_F00D);
        check_all_regs("R8 no effect");
        bus_read(5'h18, v); check("R8 unmapped read", v, 32'h0);
        bus_read(5'h1C, v); check("R8 unmapped read", v, 32'h0);

        // R7 blink from a fresh reset for phase reference
        do_reset();
        @(negedge clk);
        bus_write(5'h00, 32'hF0F0_F0F0);
        bus_write(5'h08, 32'h0000_00FF);
        check_all_regs("R7 readback");
        for (int k = 0; k < 3 * HALF; k++) begin
            check("R7 blink wave", pin_out, exp_out(m_level, m_blink, ncyc));
            @(negedge clk);
        end

        // Random mix
        for (int it = 0; it < 60; it++) begin
            logic [4:0]  a;
            logic [31:0] d;
            a = 5'(($urandom % 8) * 4);
            d = $urandom;
            bus_write(a, d);
            check_all_regs("R8 random readback");
            check("R3 random oe", pin_oe, ~m_dir);
            check("R2 R7 random out", pin_out, exp_out(m_level, m_blink, ncyc));
            pin_in = $urandom;
            repeat (2) @(negedge clk);
            bus_read(5'h10, v);
            check("R5 random data-in", v, pin_in ^ m_pol);
            check("R9 random in_view", in_view, pin_in ^ m_pol);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule